// File: doc/BRIEF.md
# Guarded ROM Bus Interface with Programmable Wait States

This block sits between a processor-style bus and an on-chip read-only array. Each bus cycle begins with a one-clock start strobe that carries an address, a 3-bit function code, a write flag and write data. The block first decides whether the cycle targets its own two control registers or the relocatable array window. It then checks the function code against the privilege policy held in the control register. If the cycle is accepted, the block waits a programmed number of clocks and then pulses a transfer acknowledge. Read data is valid in the same clock as that pulse.

A rejected cycle gets no acknowledge, so decode logic outside the block can claim it. The control register holds the wait code, the space policy and a lock bit. A second register holds the upper address bits of the array window. Reset values for the wait code, the policy and the window base are build-time parameters. Once the lock is set, it freezes all of these fields until the next reset.

Top module: `guarded_rom_biu`

## Requirements
- R1: After reset, the control word reads the parameter defaults for wait code (bits 1:0) and space policy (bits 3:2), with the lock (bit 15) clear. The base register reads the default window base in its low bits. `ack` is low.
- R2: A cycle is an array hit only when addr bits above the array size (18 bits by default) equal the base register. A cycle that hits neither the array nor the registers is never acknowledged.
- R3: The function code carries supervisor in bit 2, and data 01 or program 10 in bits 1:0. Policy 00 admits data or program at either privilege. Policy 01 admits program only (x10). Policy 10 admits supervisor data or supervisor program (101, 110). Policy 11 admits supervisor program only (110).
- R4: An array cycle whose function code fails the policy is never acknowledged and returns no data.
- R5: The total transfer length, counting the start-strobe clock as clock 1, is 3 clocks for wait code 00, 4 for 01, 5 for 10 and 2 for 11. The acknowledge falls on the last of these clocks.
- R6: Control register accesses use the same wait code as array accesses.
- R7: `ack` is high for exactly one clock per accepted cycle. `rdata` holds the array word or the register value in that clock.
- R8: While unlocked, a write to the control word (addr bit 1 = 0) updates the wait code, the policy and the lock. A write to the base word (addr bit 1 = 1) moves the array window. New values govern the cycles that follow.
- R9: Once the lock is 1, it stays 1 until reset. Later writes are still acknowledged but change no field.
- R10: The registers sit at the word pair starting at REG_BASE. They answer only supervisor function codes (bit 2 = 1); a user-mode register access is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset |
| cyc_start | input | 1 | One-clock strobe that opens a bus cycle |
| addr | input | ADDR_W | Byte address of the cycle |
| fc | input | 3 | Function code: bit 2 supervisor, bits 1:0 space |
| we | input | 1 | Cycle is a write |
| wdata | input | DATA_W | Write data for register writes |
| ack | output | 1 | One-clock data-transfer acknowledge |
| rdata | output | DATA_W | Read data, valid while ack is high |
| arr_addr | output | ARR_AW | Offset of the captured cycle inside the array |
| arr_rdata | input | DATA_W | Word returned by the array for arr_addr |

## Verification
The bench builds the block with a 24-bit address, a 256 KB array and 16-bit data. The default window base is set to 0x100000, so hits, misses and later relocation to the top of the space can all be reached with short address patterns. The reset wait code 00 and policy 00 let the bench start from the three-clock, any-space case. It then steps through every wait code and every policy by register writes. That walk puts all four transfer lengths and all four privilege tables in reach, before the lock is set and the frozen fields are probed.

// File: rtl/guarded_rom_pkg.sv
package guarded_rom_pkg;

    localparam int CNT_W = 2;

    typedef enum logic [1:0] {
        SP_ANY       = 2'b00,
        SP_PROG      = 2'b01,
        SP_SUPV      = 2'b10,
        SP_SUPV_PROG = 2'b11
    } space_e;

    localparam logic [1:0] FC_DATA = 2'b01;
    localparam logic [1:0] FC_PROG = 2'b10;

    // counter preload = total clocks - 2
    function automatic logic [CNT_W-1:0] wait_load(input logic [1:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            2'b00:   r = 2'd1;
            2'b01:   r = 2'd2;
            2'b10:   r = 2'd3;
            default: r = 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/grb_space_check.sv
module grb_space_check
    import guarded_rom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] space,
    input  logic [2:0] fc,
    output logic       allow
);

    logic is_supv;
    logic is_data;
    logic is_prog;

    always_comb begin
        is_supv = fc[2];
        is_data = (fc[1:0] == FC_DATA);
        is_prog = (fc[1:0] == FC_PROG);
        case (space_e'(space))
            SP_ANY:       allow = is_data | is_prog;
            SP_PROG:      allow = is_prog;
            SP_SUPV:      allow = is_supv & (is_data | is_prog);
            default:      allow = is_supv & is_prog;
        endcase
    end

    AST_ALLOW_VALID_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        allow |-> (fc[1] ^ fc[0])); // R3

    AST_STRICT_SUPV_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (allow && space == 2'b11) |-> (fc == 3'b110)); // R3

endmodule

// File: rtl/grb_wait_timer.sv
module grb_wait_timer
    import guarded_rom_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             busy,
    output logic             done
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = load;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.busy && (st_q.cnt == '0);

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_SHORTEST_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && load == '0) |=> done); // R5

    AST_LONG_WAIT_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && load != '0) |=> !done); // R5

endmodule

// File: rtl/grb_ctrl_regs.sv
module grb_ctrl_regs #(
    parameter int         DATA_W    = 16,
    parameter int         BASE_W    = 6,
    parameter logic [1:0] RST_WAIT  = 2'b00,
    parameter logic [1:0] RST_SPACE = 2'b00,
    parameter logic [BASE_W-1:0] RST_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [DATA_W-1:0] wd,
    output logic [1:0]        wait_code,
    output logic [1:0]        space,
    output logic              lock,
    output logic [BASE_W-1:0] base,
    output logic [DATA_W-1:0] rd
);

    localparam int LOCK_BIT = DATA_W - 1;

    typedef struct packed {
        logic [1:0]        wcode;
        logic [1:0]        space;
        logic              lock;
        logic [BASE_W-1:0] base;
    } regs_t;

    regs_t st_d, st_q;
    logic  unused_wd;

    assign unused_wd = ^wd;

    always_comb begin
        st_d = st_q;
        if (wr && !st_q.lock) begin
            if (!sel) begin
                st_d.wcode = wd[1:0];
                st_d.space = wd[3:2];
                st_d.lock  = wd[LOCK_BIT];
            end else begin
                st_d.base = wd[BASE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wcode <= RST_WAIT;
            st_q.space <= RST_SPACE;
            st_q.lock  <= 1'b0;
            st_q.base  <= RST_BASE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd = '0;
        if (!sel) begin
            rd[1:0]      = st_q.wcode;
            rd[3:2]      = st_q.space;
            rd[LOCK_BIT] = st_q.lock;
        end else begin
            rd[BASE_W-1:0] = st_q.base;
        end
    end

    assign wait_code = st_q.wcode;
    assign space     = st_q.space;
    assign lock      = st_q.lock;
    assign base      = st_q.base;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock); // R9

    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> ($stable(st_q.wcode) && $stable(st_q.space) && $stable(st_q.base))); // R9

    AST_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(st_q)); // R8

endmodule

// File: rtl/guarded_rom_biu.sv
module guarded_rom_biu
    import guarded_rom_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int ARR_AW = 18,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] REG_BASE      = 24'hFFF820,
    parameter logic [ADDR_W-1:0] RST_BASE_ADDR = 24'h100000,
    parameter logic [1:0]        RST_WAIT      = 2'b00,
    parameter logic [1:0]        RST_SPACE     = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        fc,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ARR_AW-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_rdata
);

    localparam int BASE_W = ADDR_W - ARR_AW;
    localparam logic [BASE_W-1:0] RST_BASE = RST_BASE_ADDR[ADDR_W-1:ARR_AW];

    typedef struct packed {
        logic              is_reg;
        logic              sel;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [ARR_AW-1:0] aaddr;
    } cyc_t;

    cyc_t st_d, st_q;

    logic              reg_hit;
    logic              arr_hit;
    logic              allow;
    logic              accept;
    logic              tmr_busy;
    logic              tmr_done;
    logic              reg_wr;
    logic [1:0]        wait_code;
    logic [1:0]        space;
    logic              lock;
    logic [BASE_W-1:0] base;
    logic [DATA_W-1:0] reg_rd;
    logic [CNT_W-1:0]  load;
    logic              unused_lock;

    assign unused_lock = lock;

    grb_space_check u_space (
        .clk   (clk),
        .rst_n (rst_n),
        .space (space),
        .fc    (fc),
        .allow (allow)
    );

    always_comb begin
        reg_hit = (addr[ADDR_W-1:2] == REG_BASE[ADDR_W-1:2]);
        arr_hit = (addr[ADDR_W-1:ARR_AW] == base);
        if (reg_hit) begin
            accept = cyc_start && !tmr_busy && fc[2];
        end else begin
            accept = cyc_start && !tmr_busy && arr_hit && allow;
        end
        load = wait_load(wait_code);
    end

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.is_reg = reg_hit;
            st_d.sel    = addr[1];
            st_d.we     = we;
            st_d.wdata  = wdata;
            st_d.aaddr  = addr[ARR_AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    grb_wait_timer u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .load  (load),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    assign reg_wr = tmr_done && st_q.is_reg && st_q.we;

    grb_ctrl_regs #(
        .DATA_W    (DATA_W),
        .BASE_W    (BASE_W),
        .RST_WAIT  (RST_WAIT),
        .RST_SPACE (RST_SPACE),
        .RST_BASE  (RST_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .sel       (st_q.sel),
        .wd        (st_q.wdata),
        .wait_code (wait_code),
        .space     (space),
        .lock      (lock),
        .base      (base),
        .rd        (reg_rd)
    );

    always_comb begin
        ack      = tmr_done;
        arr_addr = st_q.aaddr;
        rdata    = '0;
        if (tmr_done) begin
            rdata = st_q.is_reg ? reg_rd : arr_rdata;
        end
    end

    AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !tmr_busy && !reg_hit && !arr_hit) |=> !tmr_busy); // R2

    AST_DENIED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !tmr_busy && !reg_hit && !allow) |=> !tmr_busy); // R4

    AST_USER_REG_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !tmr_busy && reg_hit && !fc[2]) |=> !tmr_busy); // R10

    AST_NO_DATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> (rdata == '0)); // R7

endmodule

// File: tb/tb_guarded_rom_biu.sv
module tb_guarded_rom_biu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_start = 1'b0;
    logic [23:0] addr = '0;
    logic [2:0]  fc = '0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [17:0] arr_addr;
    logic [15:0] arr_rdata;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    localparam logic [23:0] CTRL_A = 24'hFFF820;
    localparam logic [23:0] BASE_A = 24'hFFF822;

    always #10 clk = ~clk;

    assign arr_rdata = arr_addr[15:0] ^ 16'h5A3C;

    guarded_rom_biu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .addr      (addr),
        .fc        (fc),
        .we        (we),
        .wdata     (wdata),
        .ack       (ack),
        .rdata     (rdata),
        .arr_addr  (arr_addr),
        .arr_rdata (arr_rdata)
    );

    bit          q_ack[$];
    int          q_n[$];
    bit          q_chk[$];
    logic [15:0] q_dat[$];
    string       q_req[$];

    bit          active = 1'b0;
    bit          chk_low = 1'b0;
    int          cnt = 0;
    bit          c_ack;
    int          c_n;
    bit          c_chk;
    logic [15:0] c_dat;
    string       c_req;

    function automatic int clocks(input logic [1:0] w);
        case (w)
            2'b00:   return 3;
            2'b01:   return 4;
            2'b10:   return 5;
            default: return 2;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [23:0] a, input logic [2:0] f, input logic w,
                          input logic [15:0] wd, input bit eack, input int en,
                          input bit chk, input logic [15:0] ed, input string req);
        q_ack.push_back(eack);
        q_n.push_back(en);
        q_chk.push_back(chk);
        q_dat.push_back(ed);
        q_req.push_back(req);
        @(posedge clk);
        #2;
        addr = a; fc = f; we = w; wdata = wd; cyc_start = 1'b1;
        @(posedge clk);
        #2;
        cyc_start = 1'b0;
        repeat (9) @(posedge clk);
    endtask

    // monitor: pops expected items and compares against ack / rdata
    always @(negedge clk) begin
        if (rst_n) begin
            if (chk_low) begin
                check(!ack, "R7", "ack not single pulse", ack, 0);
                chk_low = 1'b0;
            end
            if (active) cnt++;
            if (cyc_start) begin
                c_ack = q_ack.pop_front();
                c_n   = q_n.pop_front();
                c_chk = q_chk.pop_front();
                c_dat = q_dat.pop_front();
                c_req = q_req.pop_front();
                active = 1'b1;
                cnt = 1;
            end
            if (ack) begin
                if (!active) begin
                    check(1'b0, "R7", "ack with no cycle", 1, 0);
                end else begin
                    check(c_ack, c_req, "unexpected ack", 1, 0);
                    if (c_ack) begin
                        check(cnt == c_n, c_req, "transfer clocks", cnt, c_n);
                        if (c_chk) check(rdata == c_dat, c_req, "rdata", rdata, c_dat);
                    end
                    active = 1'b0;
                    chk_low = 1'b1;
                end
            end else if (active && cnt >= 7) begin
                check(!c_ack, c_req, "missing ack", 0, 1);
                active = 1'b0;
            end
        end
    end

    function automatic logic [15:0] aw(input logic [23:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(!ack, "R1", "ack after reset", ack, 0);

        // R1 / R6: reset defaults read back, wait 00 -> 3 clocks
        access(CTRL_A, 3'b101, 0, 0, 1, 3, 1, 16'h0000, "R1");
        access(BASE_A, 3'b101, 0, 0, 1, 3, 1, 16'h0004, "R1");

        // R2 / R3 / R5: hit and miss under policy 00
        access(24'h100010, 3'b001, 0, 0, 1, 3, 1, aw(24'h100010), "R2");
        access(24'h13FFFE, 3'b110, 0, 0, 1, 3, 1, aw(24'h13FFFE), "R5");
        access(24'h140010, 3'b001, 0, 0, 0, 0, 0, 0, "R2");
        access(24'h100020, 3'b010, 0, 0, 1, 3, 1, aw(24'h100020), "R3");
        access(24'h100020, 3'b000, 0, 0, 0, 0, 0, 0, "R4");
        access(24'h100020, 3'b111, 0, 0, 0, 0, 0, 0, "R4");
        access(24'h100020, 3'b011, 0, 0, 0, 0, 0, 0, "R3");

        // R8: wait 11, policy 01 (program only)
        access(CTRL_A, 3'b101, 1, 16'h0007, 1, 3, 0, 0, "R8");
        access(24'h100040, 3'b010, 0, 0, 1, clocks(2'b11), 1, aw(24'h100040), "R5");
        access(24'h100040, 3'b001, 0, 0, 0, 0, 0, 0, "R3");
        access(24'h100040, 3'b110, 0, 0, 1, 2, 1, aw(24'h100040), "R3");

        // wait 01, policy 10 (supervisor data/program)
        access(CTRL_A, 3'b110, 1, 16'h0009, 1, 2, 0, 0, "R8");
        access(24'h100080, 3'b101, 0, 0, 1, clocks(2'b01), 1, aw(24'h100080), "R5");
        access(24'h100080, 3'b001, 0, 0, 0, 0, 0, 0, "R3");
        access(24'h100080, 3'b010, 0, 0, 0, 0, 0, 0, "R3");
        access(24'h100080, 3'b110, 0, 0, 1, 4, 1, aw(24'h100080), "R3");

        // wait 10, policy 11 (supervisor program only)
        access(CTRL_A, 3'b101, 1, 16'h000E, 1, 4, 0, 0, "R8");
        access(24'h1000A0, 3'b110, 0, 0, 1, clocks(2'b10), 1, aw(24'h1000A0), "R5");
        access(24'h1000A0, 3'b101, 0, 0, 0, 0, 0, 0, "R3");
        access(CTRL_A, 3'b101, 0, 0, 1, 5, 1, 16'h000E, "R6");

        // R10: user access to registers ignored, value unchanged
        access(CTRL_A, 3'b001, 1, 16'h0000, 0, 0, 0, 0, "R10");
        access(CTRL_A, 3'b010, 0, 0, 0, 0, 0, 0, "R10");
        access(CTRL_A, 3'b110, 0, 0, 1, 5, 1, 16'h000E, "R10");

        // R8: relocate array window to 0xFC0000
        access(BASE_A, 3'b101, 1, 16'h003F, 1, 5, 0, 0, "R8");
        access(24'hFC0100, 3'b110, 0, 0, 1, 5, 1, aw(24'hFC0100), "R8");
        access(24'h100010, 3'b110, 0, 0, 0, 0, 0, 0, "R8");

        // R9: lock together with new fields, then frozen
        access(CTRL_A, 3'b101, 1, 16'h8003, 1, 5, 0, 0, "R9");
        access(CTRL_A, 3'b101, 0, 0, 1, 2, 1, 16'h8003, "R9");
        access(CTRL_A, 3'b101, 1, 16'h0008, 1, 2, 0, 0, "R9");
        access(CTRL_A, 3'b101, 0, 0, 1, 2, 1, 16'h8003, "R9");
        access(BASE_A, 3'b101, 1, 16'h0004, 1, 2, 0, 0, "R9");
        access(BASE_A, 3'b101, 0, 0, 1, 2, 1, 16'h003F, "R9");
        access(24'h100010, 3'b001, 0, 0, 0, 0, 0, 0, "R9");
        access(24'hFC0200, 3'b001, 0, 0, 1, 2, 1, aw(24'hFC0200), "R9");

        repeat (4) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule